// File: doc/BRIEF.md
# Erased-Chunk Bitflip Threshold Checker

This block decides whether one ECC chunk read back from NAND flash is an erased region that has picked up a few bitflips, or genuinely programmed content. After a start pulse has captured an 8-bit bitflip budget, the chunk streams in one byte per accepted transfer. Each byte carries a region tag: payload data first, then parity bytes, then an optional run of extra spare bytes. The block counts the zero bits of every byte against a single budget that the three regions share in order.

When the last byte has been accepted, the block presents a result. It either gives the total number of zero bits, together with a per-region flag that tells the surrounding logic which regions to overwrite with all-ones, or it raises an uncorrectable flag. Once the running total goes past the budget, counting stops. The rest of the chunk is still accepted and dropped, so the producer never stalls.

Top module: `erased_chunk_checker`

## Requirements
- R1: After reset, `res_valid_o` and `in_ready_o` are both 0.
- R2: `in_ready_o` is 0 while idle, so no byte is consumed before a start pulse. It is 1 on every cycle after the start pulse until the last byte has been accepted.
- R3: Each byte contributes the number of its zero bits (8 minus its ones). On success, `res_count_o` is the sum of those counts over all three regions.
- R4: The budget is shared in order across the regions: a later region may only use what earlier regions left. The chunk is uncorrectable exactly when the running total exceeds the captured threshold, so a total equal to the threshold passes.
- R5: `res_valid_o` rises on the cycle after the byte with `in_last_i` = 1 is accepted.
- R6: On success, `res_fill_o` bit 0 (data, tag 0), bit 1 (parity, tag 1) and bit 2 (spare, tag 2) is 1 exactly when that region counted at least one zero bit. On an uncorrectable result, `res_uncorr_o` is 1 and both `res_count_o` and `res_fill_o` are 0.
- R7: The spare region may be empty: a chunk whose last byte carries the parity tag is checked normally.
- R8: After the budget is exceeded, the remaining bytes are accepted one per cycle (`in_ready_o` = 1) until `in_last_i`, and they do not change the outcome.
- R9: The result is held stable until `res_ready_i` is 1. The block then returns to idle on the next cycle.
- R10: A start pulse while a chunk is in progress or a result is pending is ignored, and the threshold already captured stays in force.
- R11: Counters saturate at 255 and never wrap. With a threshold of 255, a chunk holding 256 zero bits is uncorrectable, and one holding 255 passes with a count of 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures `thresh_i` when idle |
| thresh_i | input | 8 | Bitflip budget for the chunk |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high with valid |
| in_byte_i | input | 8 | Byte read from flash |
| in_region_i | input | 2 | Region tag: 0 data, 1 parity, 2 spare |
| in_last_i | input | 1 | Marks the final byte of the chunk |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result acknowledge |
| res_uncorr_o | output | 1 | Chunk is not an erased region |
| res_count_o | output | 8 | Total bitflips on success, 0 otherwise |
| res_fill_o | output | 3 | Per-region overwrite-with-ones flags |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, an 8-bit threshold and counters, and three regions. At these widths a 32-byte run of zero bytes reaches 256 zero bits, one more than the counters can hold, so the saturation and no-wrap boundary of R11 falls within a short test. The budget-equal and budget-plus-one cases, an abort on the very first byte, and a chunk with no spare region are all reachable with chunks of a few bytes.

// File: rtl/ecc_erase_pkg.sv
`timescale 1ns/1ps
package ecc_erase_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } chk_state_e;
endpackage

// File: rtl/ecc_zero_count.sv
`timescale 1ns/1ps
module ecc_zero_count #(
    parameter int W  = 8,
    localparam int ZW = $clog2(W + 1)
) (
    input  logic [W-1:0]  byte_i,
    output logic [ZW-1:0] zeros_o
);
    always_comb begin
        zeros_o = '0;
        for (int i = 0; i < W; i++) begin
            zeros_o = zeros_o + ZW'(!byte_i[i]);
        end
    end
endmodule

// File: rtl/ecc_budget_cmp.sv
`timescale 1ns/1ps
module ecc_budget_cmp #(
    parameter int ZW = 4,
    parameter int CW = 8
) (
    input  logic [CW-1:0] total_i,
    input  logic [ZW-1:0] zeros_i,
    input  logic [CW-1:0] thr_i,
    output logic [CW-1:0] sum_o,
    output logic          over_o
);
    logic [CW:0] wide;

    always_comb begin
        wide   = {1'b0, total_i} + (CW + 1)'(zeros_i);
        over_o = wide > {1'b0, thr_i};
        sum_o  = wide[CW] ? '1 : wide[CW-1:0];
    end
endmodule

// File: rtl/ecc_region_tally.sv
`timescale 1ns/1ps
module ecc_region_tally #(
    parameter int ZW    = 4,
    parameter int CW    = 8,
    parameter int TAG_W = 2,
    parameter int TAG   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             add_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [ZW-1:0]    zeros_i,
    output logic [CW-1:0]    count_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   wide;

    always_comb begin
        wide  = {1'b0, cnt_q} + (CW + 1)'(zeros_i);
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (add_i && (tag_i == TAG_W'(TAG))) begin
            cnt_d = wide[CW] ? '1 : wide[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/erased_chunk_checker.sv
`timescale 1ns/1ps
module erased_chunk_checker
    import ecc_erase_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8,
    parameter int N_REG  = 3,
    parameter int TAG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  thresh_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [BYTE_W-1:0] in_byte_i,
    input  logic [TAG_W-1:0]  in_region_i,
    input  logic              in_last_i,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic              res_uncorr_o,
    output logic [CNT_W-1:0]  res_count_o,
    output logic [N_REG-1:0]  res_fill_o
);
    localparam int ZW = $clog2(BYTE_W + 1);

    typedef struct packed {
        chk_state_e       state;
        logic [CNT_W-1:0] thr;
        logic [CNT_W-1:0] total;
        logic             uncorr;
    } chk_regs_t;

    chk_regs_t r_d, r_q;

    logic [ZW-1:0]    zeros;
    logic [CNT_W-1:0] sum;
    logic             over;
    logic             accept;
    logic             counting;
    logic             clr;
    logic [CNT_W-1:0] reg_cnt [N_REG];

    ecc_zero_count #(.W(BYTE_W)) u_zero (
        .byte_i  (in_byte_i),
        .zeros_o (zeros)
    );

    ecc_budget_cmp #(.ZW(ZW), .CW(CNT_W)) u_budget (
        .total_i (r_q.total),
        .zeros_i (zeros),
        .thr_i   (r_q.thr),
        .sum_o   (sum),
        .over_o  (over)
    );

    assign accept   = in_valid_i && in_ready_o;
    assign counting = accept && (r_q.state == ST_RUN) && !over;
    assign clr      = (r_q.state == ST_IDLE) && start_i;

    for (genvar g = 0; g < N_REG; g++) begin : g_tally
        ecc_region_tally #(.ZW(ZW), .CW(CNT_W), .TAG_W(TAG_W), .TAG(g)) u_tally (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr),
            .add_i   (counting),
            .tag_i   (in_region_i),
            .zeros_i (zeros),
            .count_o (reg_cnt[g])
        );
        assign res_fill_o[g] = (r_q.state == ST_DONE) && !r_q.uncorr && (reg_cnt[g] != '0);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.thr    = thresh_i;
                    r_d.total  = '0;
                    r_d.uncorr = 1'b0;
                    r_d.state  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (accept) begin
                    if (over) begin
                        r_d.uncorr = 1'b1;
                        r_d.state  = in_last_i ? ST_DONE : ST_DRAIN;
                    end else begin
                        r_d.total = sum;
                        if (in_last_i) r_d.state = ST_DONE;
                    end
                end
            end
            ST_DRAIN: begin
                if (accept && in_last_i) r_d.state = ST_DONE;
            end
            ST_DONE: begin
                if (res_ready_i) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, thr: '0, total: '0, uncorr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready_o   = (r_q.state == ST_RUN) || (r_q.state == ST_DRAIN);
    assign res_valid_o  = (r_q.state == ST_DONE);
    assign res_uncorr_o = res_valid_o && r_q.uncorr;
    assign res_count_o  = (res_valid_o && !r_q.uncorr) ? r_q.total : '0;
endmodule

// File: rtl/erased_chunk_checker_sva.sv
`timescale 1ns/1ps
module erased_chunk_checker_sva #(
    parameter int CNT_W = 8,
    parameter int N_REG = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] thresh_i,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             in_last_i,
    input logic             res_valid_o,
    input logic             res_ready_i,
    input logic             res_uncorr_o,
    input logic [CNT_W-1:0] res_count_o,
    input logic [N_REG-1:0] res_fill_o
);
    logic [CNT_W-1:0] thr_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_seen_q <= '0;
        else if (start_i && !in_ready_o && !res_valid_o) thr_seen_q <= thresh_i;
    end

    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !in_ready_o);

    p_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_uncorr_o) |-> (res_count_o <= thr_seen_q));

    p_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && in_last_i) |=> res_valid_o);

    p_fail_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_uncorr_o) |-> (res_count_o == '0 && res_fill_o == '0));

    p_nofill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_uncorr_o && res_count_o == '0) |-> (res_fill_o == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=>
            (res_valid_o && $stable(res_count_o) && $stable(res_uncorr_o) && $stable(res_fill_o)));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_ready_i) |=> (!res_valid_o && !in_ready_o));
endmodule

bind erased_chunk_checker erased_chunk_checker_sva #(.CNT_W(CNT_W), .N_REG(N_REG)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .thresh_i     (thresh_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .in_last_i    (in_last_i),
    .res_valid_o  (res_valid_o),
    .res_ready_i  (res_ready_i),
    .res_uncorr_o (res_uncorr_o),
    .res_count_o  (res_count_o),
    .res_fill_o   (res_fill_o)
);

// File: tb/erased_chunk_checker_bench.sv
`timescale 1ns/1ps
module erased_chunk_checker_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] thresh_i = '0;
    logic       in_valid_i = 1'b0;
    logic       in_ready_o;
    logic [7:0] in_byte_i = '0;
    logic [1:0] in_region_i = '0;
    logic       in_last_i = 1'b0;
    logic       res_valid_o;
    logic       res_ready_i = 1'b0;
    logic       res_uncorr_o;
    logic [7:0] res_count_o;
    logic [2:0] res_fill_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    erased_chunk_checker u_erased_chunk_checker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .thresh_i(thresh_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_byte_i(in_byte_i),
        .in_region_i(in_region_i), .in_last_i(in_last_i), .res_valid_o(res_valid_o),
        .res_ready_i(res_ready_i), .res_uncorr_o(res_uncorr_o),
        .res_count_o(res_count_o), .res_fill_o(res_fill_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] thr);
        start_i  = 1'b1;
        thresh_i = thr;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input logic [1:0] tag, input logic last);
        in_valid_i  = 1'b1;
        in_byte_i   = b;
        in_region_i = tag;
        in_last_i   = last;
        chk("R2/R8 ready while streaming", int'(in_ready_o), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        in_last_i  = 1'b0;
    endtask

    task automatic expect_result(input string req, input int unc, input int cnt, input int fill);
        chk({req, " R5 valid"}, int'(res_valid_o), 1);
        chk({req, " uncorr"}, int'(res_uncorr_o), unc);
        chk({req, " count"}, int'(res_count_o), cnt);
        chk({req, " fill"}, int'(res_fill_o), fill);
    endtask

    task automatic ack();
        res_ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_ready_i = 1'b0;
        chk("R9 idle after ack valid", int'(res_valid_o), 0);
        chk("R9 idle after ack ready", int'(in_ready_o), 0);
    endtask

    task automatic t_reset();
        chk("R1 reset valid", int'(res_valid_o), 0);
        chk("R1 reset ready", int'(in_ready_o), 0);
        in_valid_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 idle refuses byte", int'(in_ready_o), 0);
        in_valid_i = 1'b0;
    endtask

    task automatic t_clean();
        pulse_start(8'd4);
        for (int i = 0; i < 4; i++) push(8'hFF, 2'd0, 1'b0);
        push(8'hFF, 2'd1, 1'b0);
        push(8'hFF, 2'd1, 1'b0);
        push(8'hFF, 2'd2, 1'b0);
        push(8'hFF, 2'd2, 1'b1);
        expect_result("R3 clean chunk", 0, 0, 3'b000);
        ack();
    endtask

    task automatic t_flips();
        pulse_start(8'd8);
        push(8'hFF, 2'd0, 1'b0);
        push(8'hFE, 2'd0, 1'b0);
        push(8'h7F, 2'd0, 1'b0);
        push(8'hF0, 2'd1, 1'b0);
        push(8'hFF, 2'd2, 1'b0);
        push(8'hFF, 2'd2, 1'b1);
        expect_result("R3 R6 scattered flips", 0, 6, 3'b011);
        ack();
    endtask

    task automatic t_exact();
        pulse_start(8'd8);
        push(8'hFF, 2'd0, 1'b0);
        push(8'hFF, 2'd1, 1'b0);
        push(8'hFE, 2'd2, 1'b0);
        push(8'h80, 2'd2, 1'b1);
        expect_result("R4 equal to budget", 0, 8, 3'b100);
        ack();
    endtask

    task automatic t_over();
        pulse_start(8'd7);
        push(8'hE0, 2'd0, 1'b0);
        push(8'hFC, 2'd1, 1'b0);
        push(8'hFE, 2'd2, 1'b1);
        expect_result("R4 R6 cascade over by one", 1, 0, 3'b000);
        ack();
    endtask

    task automatic t_abort();
        pulse_start(8'd3);
        push(8'h00, 2'd0, 1'b0);
        for (int i = 0; i < 4; i++) push(8'hFF, 2'd0, 1'b0);
        push(8'hFF, 2'd1, 1'b0);
        chk("R8 no early result", int'(res_valid_o), 0);
        push(8'hFF, 2'd2, 1'b1);
        expect_result("R8 abort drains", 1, 0, 3'b000);
        ack();
    endtask

    task automatic t_no_spare();
        pulse_start(8'd10);
        push(8'hFB, 2'd0, 1'b0);
        push(8'hFF, 2'd0, 1'b0);
        push(8'hFE, 2'd1, 1'b1);
        expect_result("R7 empty spare", 0, 2, 3'b011);
        ack();
    endtask

    task automatic t_hold();
        pulse_start(8'd20);
        push(8'h0F, 2'd0, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        expect_result("R9 held result", 0, 4, 3'b001);
        ack();
    endtask

    task automatic t_busy_start();
        pulse_start(8'd2);
        pulse_start(8'd200);
        push(8'h0F, 2'd0, 1'b1);
        pulse_start(8'd200);
        expect_result("R10 start while busy", 1, 0, 3'b000);
        ack();
    endtask

    task automatic t_sat();
        pulse_start(8'd255);
        for (int i = 0; i < 31; i++) push(8'h00, 2'd0, 1'b0);
        push(8'h00, 2'd1, 1'b1);
        expect_result("R11 256 zeros", 1, 0, 3'b000);
        ack();
        pulse_start(8'd255);
        for (int i = 0; i < 31; i++) push(8'h00, 2'd0, 1'b0);
        push(8'h01, 2'd1, 1'b1);
        expect_result("R11 255 zeros", 0, 255, 3'b011);
        ack();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_flips();
        t_exact();
        t_over();
        t_abort();
        t_no_spare();
        t_hold();
        t_busy_start();
        t_sat();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule